// File: doc/BRIEF.md
# Adapter Setup Configuration Register File

This block holds the setup-time option bytes of a plug-in bus adapter. During setup, system software reaches eight byte-wide locations through a strobed byte port. The port has a setup-select line, a 3-bit index, read and write strobes, and separate write and read data buses. Two locations hold a fixed adapter identifier and cannot be written. The other six store option bytes, and these bytes drive the rest of the card.

One bit of the control byte is the card enable. While it is clear, the block blocks every address-decode hit and interrupt request that the adapter logic presents to it. A second bit of that byte selects a bus fairness mode. The error byte carries two indicator bits. External channel-check inputs set them, and they stay set until software rewrites the byte or reset occurs. The last two locations form a 16-bit sub-address extension.

Read data is registered: it appears on the cycle after the read strobe and holds between reads.

Top module: `adp_cfg_regs`

## Requirements
- R1: A selected read of index 0 returns 0x6D and a selected read of index 1 returns 0x6E.
- R2: Selected writes to index 0 or 1 change no stored byte, no output and no later read of index 0 or 1.
- R3: A selected write to index 2, 3, 4, 6 or 7 stores the data byte, and a later read of that index returns it. Index 2..5 bytes appear on opt2_o..opt5_o. subaddr_o carries index 7 in bits 15:8 and index 6 in bits 7:0.
- R4: card_en_o equals bit 0 of the index-2 byte and fair_en_o equals bit 7 of the index-2 byte.
- R5: dec_o equals raw_dec_i and irq_o equals raw_irq_i while card_en_o is 1. Both are 0 while card_en_o is 0.
- R6: chk_act_i high at a clock edge sets bit 7 of the index-5 byte. The bit stays set until a selected write to index 5 or reset. If the input is high during that same write, the bit is still set.
- R7: chk_stat_i sets bit 6 of the index-5 byte, with the same holding and precedence rules as in R6.
- R8: Reset (synchronous, active high) clears all writable bytes and rdat_o to 0, so the card comes up disabled.
- R9: rdat_o updates on the clock edge where sel_i and rd_i are both high. It holds its value at every other edge, and strobes with sel_i low have no effect.
- R10: When a read and a write to the same index occur at the same edge, rdat_o returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Setup-window select |
| idx_i | input | 3 | Register index |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdat_i | input | 8 | Write data |
| rdat_o | output | 8 | Registered read data |
| chk_act_i | input | 1 | Channel-check active set pulse |
| chk_stat_i | input | 1 | Channel-check status available set pulse |
| raw_dec_i | input | 1 | Address-decode hit from adapter logic |
| raw_irq_i | input | 1 | Interrupt request from adapter logic |
| dec_o | output | 1 | Decode hit gated by card enable |
| irq_o | output | 1 | Interrupt gated by card enable |
| card_en_o | output | 1 | Card enable |
| fair_en_o | output | 1 | Fairness mode enable |
| opt2_o | output | 8 | Index-2 byte |
| opt3_o | output | 8 | Index-3 byte |
| opt4_o | output | 8 | Index-4 byte |
| opt5_o | output | 8 | Index-5 byte |
| subaddr_o | output | 16 | Sub-address extension |

## Verification
The assertions assume that the strobes, the index and the data are synchronous to clk and settle before each rising edge. They also assume the channel-check inputs are level-sampled pulses, so a single edge sees each assertion of them. The bench drives every input on the falling edge and holds it for one whole cycle, which keeps it within these assumptions. The bench uses random indices, data and channel-check pulses, and adds directed cases for write/set collisions and for same-edge read and write.

// File: rtl/adp_cfg_pkg.sv
package adp_cfg_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 3;
  localparam int NREG     = 8;
  localparam int FIRST_RW = 2;
  localparam logic [DATA_W-1:0] ID_LO = 8'h6D;
  localparam logic [DATA_W-1:0] ID_HI = 8'h6E;
  localparam int OFF_CTL  = 2;
  localparam int OFF_ERR  = 5;
  localparam int OFF_SLO  = 6;
  localparam int OFF_SHI  = 7;
  localparam int BIT_CEN  = 0;
  localparam int BIT_FAIR = 7;
  localparam int BIT_ACT  = 7;
  localparam int BIT_STAT = 6;
endpackage

// File: rtl/adp_cfg_store.sv
module adp_cfg_store
  import adp_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int NR = NREG
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [DW-1:0]         wr_data,
  input  logic                  chk_act,
  input  logic                  chk_stat,
  output logic [NR-1:0][DW-1:0] bank_o
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    if (g < FIRST_RW) begin : g_ro
      assign bank_o[g] = '0;
    end else if (g == OFF_ERR) begin : g_err
      logic          hit;
      logic [DW-1:0] q, nxt;
      assign hit = wr_en && (wr_idx == IW'(g));
      always_comb begin
        nxt = hit ? wr_data : q;
        nxt[BIT_ACT]  = nxt[BIT_ACT]  | chk_act;
        nxt[BIT_STAT] = nxt[BIT_STAT] | chk_stat;
      end
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
      end
      assign bank_o[g] = q;

      assert_act_set_R6: assert property (@(posedge clk) disable iff (rst)
        chk_act |=> bank_o[g][BIT_ACT]);
      assert_stat_set_R7: assert property (@(posedge clk) disable iff (rst)
        chk_stat |=> bank_o[g][BIT_STAT]);
      assert_act_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!chk_act && !hit) |=> $stable(bank_o[g][BIT_ACT]));
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                              q <= '0;
        else if (wr_en && wr_idx == IW'(g))   q <= wr_data;
      end
      assign bank_o[g] = q;

      assert_wr_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IW'(g)) |=> bank_o[g] == $past(wr_data));
    end
  end
endmodule

// File: rtl/adp_cfg_rdmux.sv
module adp_cfg_rdmux
  import adp_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int NR = NREG
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [IW-1:0]         rd_idx,
  input  logic [NR-1:0][DW-1:0] bank,
  output logic [DW-1:0]         rdat_q
);
  logic [DW-1:0] sel_byte;

  always_comb begin
    if (rd_idx == IW'(0))      sel_byte = ID_LO;
    else if (rd_idx == IW'(1)) sel_byte = ID_HI;
    else                       sel_byte = bank[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdat_q <= '0;
    else if (rd_en) rdat_q <= sel_byte;
  end

  assert_id_lo_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == IW'(0)) |=> rdat_q == 8'h6D);
  assert_id_hi_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_idx == IW'(1)) |=> rdat_q == 8'h6E);
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdat_q));
endmodule

// File: rtl/adp_cfg_regs.sv
module adp_cfg_regs
  import adp_cfg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int NR = NREG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_i,
  input  logic [IW-1:0]   idx_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdat_i,
  output logic [DW-1:0]   rdat_o,
  input  logic            chk_act_i,
  input  logic            chk_stat_i,
  input  logic            raw_dec_i,
  input  logic            raw_irq_i,
  output logic            dec_o,
  output logic            irq_o,
  output logic            card_en_o,
  output logic            fair_en_o,
  output logic [DW-1:0]   opt2_o,
  output logic [DW-1:0]   opt3_o,
  output logic [DW-1:0]   opt4_o,
  output logic [DW-1:0]   opt5_o,
  output logic [2*DW-1:0] subaddr_o
);
  logic                  rd_en, wr_en;
  logic [NR-1:0][DW-1:0] bank;

  assign rd_en = sel_i && rd_i;
  assign wr_en = sel_i && wr_i;

  adp_cfg_store #(.DW(DW), .IW(IW), .NR(NR)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx_i), .wr_data(wdat_i),
    .chk_act(chk_act_i), .chk_stat(chk_stat_i), .bank_o(bank)
  );

  adp_cfg_rdmux #(.DW(DW), .IW(IW), .NR(NR)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(idx_i), .bank(bank),
    .rdat_q(rdat_o)
  );

  assign card_en_o = bank[OFF_CTL][BIT_CEN];
  assign fair_en_o = bank[OFF_CTL][BIT_FAIR];
  assign opt2_o    = bank[2];
  assign opt3_o    = bank[3];
  assign opt4_o    = bank[4];
  assign opt5_o    = bank[OFF_ERR];
  assign subaddr_o = {bank[OFF_SHI], bank[OFF_SLO]};
  assign dec_o     = raw_dec_i && card_en_o;
  assign irq_o     = raw_irq_i && card_en_o;

  assert_rst_clear_R8: assert property (@(posedge clk)
    rst |=> (!card_en_o && rdat_o == '0 && subaddr_o == '0));
  assert_ro_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_i < IW'(FIRST_RW) && !chk_act_i && !chk_stat_i)
      |=> ($stable(opt2_o) && $stable(opt5_o) && $stable(subaddr_o)));
endmodule

// File: tb/adp_cfg_regs_bench.sv
`timescale 1ns/1ps
module adp_cfg_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 0, rd = 0, wr = 0, act = 0, stat = 0, rdec = 0, rirq = 0;
  logic [2:0] idx = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdat, o2, o3, o4, o5;
  logic [15:0] sub;
  logic dec, irq, cen, fair;

  int checks = 0, failures = 0;
  logic [7:0] m [0:7];
  logic [7:0] mrd;

  always #2.5 clk = ~clk;

  adp_cfg_regs u_adp_cfg_regs (
    .clk(clk), .rst(rst), .sel_i(sel), .idx_i(idx), .rd_i(rd), .wr_i(wr),
    .wdat_i(wd), .rdat_o(rdat), .chk_act_i(act), .chk_stat_i(stat),
    .raw_dec_i(rdec), .raw_irq_i(rirq), .dec_o(dec), .irq_o(irq),
    .card_en_o(cen), .fair_en_o(fair), .opt2_o(o2), .opt3_o(o3),
    .opt4_o(o4), .opt5_o(o5), .subaddr_o(sub)
  );

  function automatic logic [7:0] exp_read(input logic [2:0] i);
    if (i == 3'd0) return 8'h6D;
    if (i == 3'd1) return 8'h6E;
    return m[i];
  endfunction

  task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic check_outs();
    chk("R4 card_en", {15'd0, cen}, {15'd0, m[2][0]});
    chk("R4 fair_en", {15'd0, fair}, {15'd0, m[2][7]});
    chk("R3 opt2", {8'd0, o2}, {8'd0, m[2]});
    chk("R3 opt3", {8'd0, o3}, {8'd0, m[3]});
    chk("R3 opt4", {8'd0, o4}, {8'd0, m[4]});
    chk("R6 R7 opt5", {8'd0, o5}, {8'd0, m[5]});
    chk("R3 subaddr", sub, {m[7], m[6]});
    chk("R5 dec", {15'd0, dec}, {15'd0, rdec & m[2][0]});
    chk("R5 irq", {15'd0, irq}, {15'd0, rirq & m[2][0]});
    chk("R9 rdat", {8'd0, rdat}, {8'd0, mrd});
  endtask

  task automatic op(input logic s, input logic r, input logic w,
                    input logic [2:0] i, input logic [7:0] d,
                    input logic a, input logic st);
    @(negedge clk);
    sel = s; rd = r; wr = w; idx = i; wd = d; act = a; stat = st;
    @(negedge clk);
    if (s && r) mrd = exp_read(i);
    if (s && w && i >= 3'd2) m[i] = d;
    if (a)  m[5][7] = 1'b1;
    if (st) m[5][6] = 1'b1;
    sel = 0; rd = 0; wr = 0; act = 0; stat = 0;
    rdec = 1'($urandom); rirq = 1'($urandom);
    #0.1;
    check_outs();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    for (int k = 0; k < 8; k++) m[k] = 8'h00;
    mrd = 8'h00;
    #0.1;
    chk("R8 rdat after reset", {8'd0, rdat}, 16'h0000);
    check_outs();
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1: identifier
    op(1,1,0,3'd0,8'h00,0,0); chk("R1 id lo", {8'd0, rdat}, 16'h006D);
    op(1,1,0,3'd1,8'h00,0,0); chk("R1 id hi", {8'd0, rdat}, 16'h006E);
    // R2: writes to read-only ignored
    op(1,0,1,3'd0,8'hFF,0,0);
    op(1,0,1,3'd1,8'h01,0,0);
    op(1,1,0,3'd0,8'h00,0,0); chk("R2 id lo kept", {8'd0, rdat}, 16'h006D);
    op(1,1,0,3'd1,8'h00,0,0); chk("R2 id hi kept", {8'd0, rdat}, 16'h006E);
    chk("R2 card stays off", {15'd0, cen}, 16'h0000);
    // R3 / R4: each writable byte
    op(1,0,1,3'd2,8'h81,0,0);
    op(1,0,1,3'd3,8'h3C,0,0);
    op(1,0,1,3'd4,8'hA5,0,0);
    op(1,0,1,3'd6,8'h34,0,0);
    op(1,0,1,3'd7,8'h12,0,0);
    chk("R3 subaddr 1234", sub, 16'h1234);
    chk("R4 card on", {15'd0, cen}, 16'h0001);
    for (int k = 2; k < 8; k++) op(1,1,0,3'(k),8'h00,0,0);
    // R5: gating
    @(negedge clk); rdec = 1; rirq = 1; #0.1;
    chk("R5 dec passes", {15'd0, dec}, 16'h0001);
    op(1,0,1,3'd2,8'h80,0,0);
    @(negedge clk); rdec = 1; rirq = 1; #0.1;
    chk("R5 dec blocked", {15'd0, dec}, 16'h0000);
    chk("R5 irq blocked", {15'd0, irq}, 16'h0000);
    // R6 / R7: sticky indicators
    op(0,0,0,3'd0,8'h00,1,0);
    op(0,0,0,3'd0,8'h00,0,0);
    op(1,1,0,3'd5,8'h00,0,0); chk("R6 act sticky", {8'd0, rdat}, 16'h0080);
    op(1,0,1,3'd5,8'h00,0,1);
    op(1,1,0,3'd5,8'h00,0,0); chk("R7 stat set, act cleared", {8'd0, rdat}, 16'h0040);
    op(1,0,1,3'd5,8'h00,1,0);
    chk("R6 set wins over write", {8'd0, o5}, 16'h0080);
    op(1,0,1,3'd5,8'h00,0,0);
    chk("R6 write clears", {8'd0, o5}, 16'h0000);
    // R9: strobes without select ignored, data held
    op(1,1,0,3'd3,8'h00,0,0);
    op(0,1,1,3'd3,8'h77,0,0);
    chk("R9 no select", {8'd0, o3}, 16'h003C);
    chk("R9 rdat held", {8'd0, rdat}, 16'h003C);
    // R10: same-edge read and write
    op(1,1,1,3'd4,8'h5A,0,0); chk("R10 old value", {8'd0, rdat}, 16'h00A5);
    op(1,1,0,3'd4,8'h00,0,0); chk("R10 new value", {8'd0, rdat}, 16'h005A);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0] | r[1], r[2], r[3], r[6:4], r[15:8], r[16] & r[17] & r[18],
         r[19] & r[20] & r[21]);
    end
    // R8: reset clears after activity
    op(1,0,1,3'd2,8'hFF,0,0);
    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule